// File: doc/BRIEF.md
# Multicycle Operand Steering and Program Counter

This block sits between the control sequencer and the single shared ALU of a 32-bit multicycle processor. On each cycle it picks the two ALU operands from the program counter, the register read buffers and the instruction's immediate field. It also decides what, if anything, is written into the program counter at the next clock edge. The same ALU that does data arithmetic also forms PC+4 and branch targets. This block supplies the operand paths and next-PC choices that let it do so, so no separate adders are needed.

The sequencer drives the select codes and the write enables. The ALU result, the held ALU output register and the zero flag come back from the ALU. The instruction register stays outside this block. Only its low jump field is brought in here, and that field must remain stable until the instruction completes. The block contains no state machine. Its single piece of state is the PC register, which has two states: loading when an enable is met, and holding otherwise. It leaves the hold state only when an unconditional write is asked for, or when a conditional write is asked for and the zero flag is set. A synchronous reset returns it to the start address.

Top module: `pc_opnd_steer`

## Requirements
- R1: `opnd_a` equals `pc` when `srca_sel` is 0 and equals `buf_a` when `srca_sel` is 1, in the same cycle.
- R2: `opnd_b` equals `buf_b` for `srcb_sel` 00, the constant 4 for 01, the extended immediate for 10, and the extended immediate shifted left by two (low two bits zero) for 11.
- R3: the immediate is `ir_field[15:0]` sign-extended from bit 15: bit 15 set fills bits 31..16 with ones, clear fills them with zeros.
- R4: with `pc_src` 00 and a load, `pc` takes `alu_result` one clock edge later.
- R5: with `pc_src` 01 and a load, `pc` takes `alu_out_reg` one edge later.
- R6: with `pc_src` 10 and a load, `pc` becomes {old `pc[31:28]`, `ir_field[25:0]`, 2'b00}.
- R7: `pc_src` 11 leaves `pc` unchanged even when a load is enabled.
- R8: `pc_load` is high when `pc_we` is high, or when `pc_we_cond` and `alu_zero` are both high. With `pc_we_cond` high, `alu_zero` low and `pc_we` low, `pc` holds.
- R9: with both `pc_we` and `pc_we_cond` low, `pc` holds whatever the select and data inputs do.
- R10: `rst` high at a clock edge sets `pc` to 0x00000000. This takes priority over any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| srca_sel | input | 1 | operand A source: 0 PC, 1 buffer A |
| srcb_sel | input | 2 | operand B source code |
| pc_src | input | 2 | next-PC source code |
| pc_we | input | 1 | unconditional PC write |
| pc_we_cond | input | 1 | PC write qualified by the zero flag |
| alu_zero | input | 1 | ALU zero flag |
| buf_a | input | 32 | register read buffer A |
| buf_b | input | 32 | register read buffer B |
| ir_field | input | 26 | instruction register bits 25..0 |
| alu_result | input | 32 | live ALU result |
| alu_out_reg | input | 32 | registered ALU output |
| opnd_a | output | 32 | ALU operand A |
| opnd_b | output | 32 | ALU operand B |
| pc | output | 32 | program counter |
| pc_load | output | 1 | PC write enable in effect this cycle |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 16-bit immediate, a 26-bit jump field, a step of 4 and a start address of zero. With these values, immediates with bit 15 both set and clear reach both sign-extension fills. The PC can be preloaded with non-zero top bits, so the jump splice is shown to keep the old upper nibble. The conditional write is tried with the zero flag both high and low, and reset is applied while a load is pending.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [1:0] {
        OPB_REG      = 2'b00,
        OPB_STEP     = 2'b01,
        OPB_IMM      = 2'b10,
        OPB_IMM_WORD = 2'b11
    } opb_sel_e;

    typedef enum logic [1:0] {
        NPC_ALU  = 2'b00,
        NPC_HELD = 2'b01,
        NPC_JUMP = 2'b10,
        NPC_NONE = 2'b11
    } npc_sel_e;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
    import steer_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int STEP  = 4
) (
    input  logic            srca_sel,
    input  opb_sel_e        srcb_sel,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] buf_a,
    input  logic [XLEN-1:0] buf_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b
);
    localparam int FILL_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    generate
        if (FILL_W > 0) begin : g_extend
            assign imm_ext = {{FILL_W{imm[IMM_W-1]}}, imm};
        end else begin : g_direct
            assign imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        opnd_a = srca_sel ? buf_a : pc;
    end

    always_comb begin
        unique case (srcb_sel)
            OPB_REG:      opnd_b = buf_b;
            OPB_STEP:     opnd_b = XLEN'(STEP);
            OPB_IMM:      opnd_b = imm_ext;
            OPB_IMM_WORD: opnd_b = {imm_ext[XLEN-3:0], 2'b00};
            default:      opnd_b = buf_b;
        endcase
    end

    always_comb begin
        if (srcb_sel == OPB_IMM_WORD)
            assert_word_align_R2: assert (opnd_b[1:0] == 2'b00);
    end
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import steer_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int JTGT_W = 26
) (
    input  npc_sel_e          sel,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   alu_result,
    input  logic [XLEN-1:0]   alu_out_reg,
    input  logic [JTGT_W-1:0] jfield,
    output logic [XLEN-1:0]   npc
);
    localparam int HI_W = XLEN - JTGT_W - 2;

    logic [XLEN-1:0] jump_tgt;

    assign jump_tgt = {pc[XLEN-1 -: HI_W], jfield, 2'b00};

    always_comb begin
        unique case (sel)
            NPC_ALU:  npc = alu_result;
            NPC_HELD: npc = alu_out_reg;
            NPC_JUMP: npc = jump_tgt;
            NPC_NONE: npc = pc;
            default:  npc = pc;
        endcase
    end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            we_cond,
    input  logic            zero,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] pc,
    output logic            load
);
    assign load = we | (we_cond & zero);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_PC;
        else if (load)
            pc <= npc;
    end

    assert_reset_value_R10: assert property (@(posedge clk)
        rst |=> pc == RESET_PC);

    assert_hold_no_load_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pc));

    assert_cond_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (we_cond && !zero && !we) |=> $stable(pc));
endmodule

// File: rtl/pc_opnd_steer.sv
module pc_opnd_steer
    import steer_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              IMM_W    = 16,
    parameter int              JTGT_W   = 26,
    parameter int              STEP     = 4,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srca_sel,
    input  logic [1:0]        srcb_sel,
    input  logic [1:0]        pc_src,
    input  logic              pc_we,
    input  logic              pc_we_cond,
    input  logic              alu_zero,
    input  logic [XLEN-1:0]   buf_a,
    input  logic [XLEN-1:0]   buf_b,
    input  logic [JTGT_W-1:0] ir_field,
    input  logic [XLEN-1:0]   alu_result,
    input  logic [XLEN-1:0]   alu_out_reg,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   opnd_b,
    output logic [XLEN-1:0]   pc,
    output logic              pc_load
);
    localparam int HI_W = XLEN - JTGT_W - 2;

    logic [XLEN-1:0] npc;

    alu_opnd_sel #(.XLEN(XLEN), .IMM_W(IMM_W), .STEP(STEP)) u_opnd (
        .srca_sel (srca_sel),
        .srcb_sel (opb_sel_e'(srcb_sel)),
        .pc       (pc),
        .buf_a    (buf_a),
        .buf_b    (buf_b),
        .imm      (ir_field[IMM_W-1:0]),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b)
    );

    pc_next_sel #(.XLEN(XLEN), .JTGT_W(JTGT_W)) u_npc (
        .sel         (npc_sel_e'(pc_src)),
        .pc          (pc),
        .alu_result  (alu_result),
        .alu_out_reg (alu_out_reg),
        .jfield      (ir_field),
        .npc         (npc)
    );

    pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .we      (pc_we),
        .we_cond (pc_we_cond),
        .zero    (alu_zero),
        .npc     (npc),
        .pc      (pc),
        .load    (pc_load)
    );

    assert_opa_pc_R1: assert property (@(posedge clk) disable iff (rst)
        !srca_sel |-> opnd_a == pc);

    assert_step_const_R2: assert property (@(posedge clk) disable iff (rst)
        srcb_sel == 2'b01 |-> opnd_b == XLEN'(STEP));

    assert_alu_load_R4: assert property (@(posedge clk) disable iff (rst)
        (pc_load && pc_src == 2'b00) |=> pc == $past(alu_result));

    assert_jump_splice_R6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && pc_src == 2'b10) |=>
            (pc[XLEN-1 -: HI_W] == $past(pc[XLEN-1 -: HI_W]) && pc[1:0] == 2'b00));

    assert_unused_code_R7: assert property (@(posedge clk) disable iff (rst)
        pc_src == 2'b11 |=> $stable(pc));
endmodule

// File: tb/pc_opnd_steer_tb.sv
module pc_opnd_steer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        srca_sel;
    logic [1:0]  srcb_sel;
    logic [1:0]  pc_src;
    logic        pc_we;
    logic        pc_we_cond;
    logic        alu_zero;
    logic [31:0] buf_a;
    logic [31:0] buf_b;
    logic [25:0] ir_field;
    logic [31:0] alu_result;
    logic [31:0] alu_out_reg;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] pc;
    logic        pc_load;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_opnd_steer u_dut (
        .clk(clk), .rst(rst), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
        .pc_src(pc_src), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .alu_zero(alu_zero), .buf_a(buf_a), .buf_b(buf_b),
        .ir_field(ir_field), .alu_result(alu_result),
        .alu_out_reg(alu_out_reg), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .pc(pc), .pc_load(pc_load)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        pc_we = 0; pc_we_cond = 0; alu_zero = 0; pc_src = 2'b00;
    endtask

    // one edge, then sample 1 time unit after it
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic load_pc(input logic [31:0] v);
        @(negedge clk);
        pc_we = 1; pc_src = 2'b00; alu_result = v;
        tick();
        idle();
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1; idle(); tick();
        @(negedge clk); rst = 0;
        check("R10 reset pc", pc, 32'h0);
    endtask

    task automatic t_opnd_a();
        load_pc(32'h0000_1234);
        @(negedge clk); buf_a = 32'hCAFE_0001; srca_sel = 0; #1;
        check("R1 opnd_a pc", opnd_a, 32'h0000_1234);
        srca_sel = 1; #1;
        check("R1 opnd_a buf_a", opnd_a, 32'hCAFE_0001);
    endtask

    task automatic t_opnd_b();
        @(negedge clk); buf_b = 32'h1357_9BDF; ir_field = 26'h000_7FF0;
        srcb_sel = 2'b00; #1; check("R2 opnd_b reg", opnd_b, 32'h1357_9BDF);
        srcb_sel = 2'b01; #1; check("R2 opnd_b step", opnd_b, 32'h4);
        srcb_sel = 2'b10; #1; check("R3 imm positive", opnd_b, 32'h0000_7FF0);
        srcb_sel = 2'b11; #1; check("R2 imm word positive", opnd_b, 32'h0001_FFC0);
        ir_field = 26'h3FF_8004;
        srcb_sel = 2'b10; #1; check("R3 imm negative", opnd_b, 32'hFFFF_8004);
        srcb_sel = 2'b11; #1; check("R2 imm word negative", opnd_b, 32'hFFFE_0010);
    endtask

    task automatic t_sources();
        load_pc(32'h0000_0040);
        check("R4 load alu_result", pc, 32'h0000_0040);
        @(negedge clk); pc_we = 1; pc_src = 2'b01; alu_out_reg = 32'h0000_0888;
        alu_result = 32'hDEAD_0000; tick(); idle();
        check("R5 load alu_out_reg", pc, 32'h0000_0888);
        load_pc(32'hA000_0010);
        @(negedge clk); pc_we = 1; pc_src = 2'b10; ir_field = 26'h123_4567; tick(); idle();
        check("R6 jump target", pc, {4'hA, 26'h123_4567, 2'b00});
        @(negedge clk); pc_we = 1; pc_src = 2'b11; tick(); idle();
        check("R7 unused code holds", pc, {4'hA, 26'h123_4567, 2'b00});
    endtask

    task automatic t_cond();
        load_pc(32'h0000_0100);
        @(negedge clk); pc_we_cond = 1; alu_zero = 0; pc_src = 2'b01;
        alu_out_reg = 32'h0000_0200; #1;
        check("R8 pc_load low no zero", {31'b0, pc_load}, 32'h0);
        tick(); idle();
        check("R8 cond no zero holds", pc, 32'h0000_0100);
        @(negedge clk); pc_we_cond = 1; alu_zero = 1; pc_src = 2'b01; #1;
        check("R8 pc_load high zero", {31'b0, pc_load}, 32'h1);
        tick(); idle();
        check("R8 cond zero loads", pc, 32'h0000_0200);
        @(negedge clk); pc_src = 2'b10; alu_zero = 1; alu_result = 32'h5555_5555;
        ir_field = 26'h3FF_FFFF; tick(); tick();
        check("R9 no enable holds", pc, 32'h0000_0200);
        idle();
    endtask

    task automatic t_reset_priority();
        @(negedge clk); rst = 1; pc_we = 1; pc_src = 2'b00; alu_result = 32'h7777_0000;
        tick();
        @(negedge clk); rst = 0; idle();
        check("R10 reset beats load", pc, 32'h0);
    endtask

    initial begin
        rst = 1; srca_sel = 0; srcb_sel = 0; buf_a = 0; buf_b = 0;
        ir_field = 0; alu_result = 0; alu_out_reg = 0; idle();
        t_reset();
        t_opnd_a();
        t_opnd_b();
        t_sources();
        t_cond();
        t_reset_priority();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule